// File: doc/BRIEF.md
# Task Priority Register Bank

This block keeps one 8-bit priority entry for each of eight symmetric bus agents. The system bus writes these entries with a two-phase special cycle. A decoded strobe marks the first phase. The address carried by the next address strobe holds the payload: the target agent, a 4-bit priority and an enable flag. The bus address lines are active-low, so the block inverts the captured bits before it pulls out the fields. Software cannot write the bank. It sees all eight entries at once as a packed 64-bit word for test and debug.

A combinational hint is computed from the stored entries. It names the enabled agent whose priority value is numerically lowest, which an interrupt redirector can use as a delivery target. A valid flag goes low when every entry is disabled.

Top module: `tpr_bank`

## Requirements
- R1: After a synchronous reset every entry holds 8'h80, so the readback equals 64'h8080_8080_8080_8080 and the hint valid flag is low.
- R2: Each entry has this layout: bit 7 is the disable flag (1 means disabled, 0 means enabled), bits 6:4 always read 0, and bits 3:0 hold the priority. Agent k occupies readback bits 8k+7 down to 8k.
- R3: For a second-phase strobe, the active-low address is inverted first. The priority comes from inverted bits 27:24, the agent index from inverted bits 22:20, and the entry's disable flag is the complement of inverted bit 31 (inverted bit 31 = 1 enables the entry). Only the addressed entry changes, and the new value shows on the readback in the cycle after the strobe.
- R4: Address bit 23 and address bits 30:28 and 19:0 do not affect which entry is written or what value it receives.
- R5: A cycle with the first-phase strobe high writes nothing. It arms the tracker, and the tracker stays armed through idle cycles until the next address strobe.
- R6: An address strobe while the tracker is not armed writes nothing. After one write the tracker disarms, so a second address strobe without a new first phase is ignored.
- R7: When two enabled entries share the lowest priority, the hint picks the lower agent ID.
- R8: The hint index names an enabled entry whose priority is not above that of any other enabled entry. The valid flag is high exactly when at least one entry is enabled.
- R9: An update that sets the disable flag removes that agent from the hint in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_stb | input | 1 | Decoded first phase of the priority-update special cycle |
| addr_stb | input | 1 | Address strobe |
| addr_n | input | 32 | Active-low bus address |
| readback | output | 64 | Packed entries, agent 7 in the top byte |
| hint_idx | output | 3 | Enabled agent with the lowest priority |
| hint_vld | output | 1 | High when at least one entry is enabled |

## Verification
The update path is driven with payloads that differ in only one field at a time: index, priority, enable, bit 23, and the ignored junk bits. A wrong bit position or a missing inversion therefore lands on a different entry or a different byte of the readback. The phase tracking is exercised with several strobe orders: a stray strobe, a repeated strobe after a write, and a first phase followed by idle cycles. These separate a tracker that never arms, one that never disarms, and one that writes in the first phase. The hint is checked with equal-priority ties between two agents, with entries disabled one after another, and with the bank fully disabled. Together these show whether ties go to the right agent, whether the enable flag is taken into account, and how the valid flag behaves.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  localparam int TPR_AGENTS  = 8;
  localparam int TPR_PRIO_W  = 4;
  localparam int TPR_ENTRY_W = 8;
  localparam int TPR_ADDR_W  = 32;
  localparam int TPR_PRIO_LSB = 24;
  localparam int TPR_IDX_LSB  = 20;
  localparam int TPR_EN_BIT   = 31;
endpackage

// File: rtl/tpr_phase_tracker.sv
module tpr_phase_tracker (
  input  logic clk,
  input  logic rst,
  input  logic first_stb,
  input  logic addr_stb,
  output logic armed,
  output logic wr_go
);
  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b0;
    else if (first_stb) armed <= 1'b1;
    else if (addr_stb)  armed <= 1'b0;
  end

  assign wr_go = armed & addr_stb & ~first_stb;

  // R5
  arm_on_first_chk: assert property (@(posedge clk) disable iff (rst)
    first_stb |=> armed);
  // R6
  disarm_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !armed);
endmodule

// File: rtl/tpr_entry_store.sv
module tpr_entry_store #(
  parameter int N       = 8,
  parameter int PRIO_W  = 4,
  parameter int ENTRY_W = 8,
  localparam int IDX_W  = $clog2(N),
  localparam int RSV_W  = ENTRY_W - 1 - PRIO_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_go,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [PRIO_W-1:0]    wr_prio,
  input  logic                 wr_dis,
  output logic [N*ENTRY_W-1:0] rb
);
  logic [N-1:0] wr_sel;

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic              dis_q;
    logic [PRIO_W-1:0] prio_q;

    assign wr_sel[k] = wr_go && (wr_idx == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        dis_q  <= 1'b1;
        prio_q <= '0;
      end else if (wr_sel[k]) begin
        dis_q  <= wr_dis;
        prio_q <= wr_prio;
      end
    end

    assign rb[k*ENTRY_W +: ENTRY_W] = {dis_q, {RSV_W{1'b0}}, prio_q};

    // R3
    entry_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_go && wr_idx == IDX_W'(k)) |=>
        (rb[k*ENTRY_W +: PRIO_W] == $past(wr_prio)) &&
        (rb[k*ENTRY_W + ENTRY_W - 1] == $past(wr_dis)));
    // R3
    entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_go && wr_idx == IDX_W'(k)) |=> $stable(rb[k*ENTRY_W +: ENTRY_W]));
  end

  // R3
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/tpr_lowest_finder.sv
module tpr_lowest_finder #(
  parameter int N       = 8,
  parameter int PRIO_W  = 4,
  parameter int ENTRY_W = 8,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N*ENTRY_W-1:0] rb,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 sel_vld
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    sel_idx = '0;
    sel_vld = 1'b0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (!rb[i*ENTRY_W + ENTRY_W - 1]) begin
        if (!sel_vld || rb[i*ENTRY_W +: PRIO_W] < best) begin
          sel_vld = 1'b1;
          sel_idx = IDX_W'(i);
          best    = rb[i*ENTRY_W +: PRIO_W];
        end
      end
    end
  end

  // R8
  hint_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    sel_vld |-> !rb[32'(sel_idx)*ENTRY_W + ENTRY_W - 1]);
endmodule

// File: rtl/tpr_bank.sv
module tpr_bank
  import tpr_pkg::*;
#(
  parameter int N        = TPR_AGENTS,
  parameter int PRIO_W   = TPR_PRIO_W,
  parameter int ENTRY_W  = TPR_ENTRY_W,
  parameter int ADDR_W   = TPR_ADDR_W,
  parameter int PRIO_LSB = TPR_PRIO_LSB,
  parameter int IDX_LSB  = TPR_IDX_LSB,
  parameter int EN_BIT   = TPR_EN_BIT,
  localparam int IDX_W   = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 first_stb,
  input  logic                 addr_stb,
  input  logic [ADDR_W-1:0]    addr_n,
  output logic [N*ENTRY_W-1:0] readback,
  output logic [IDX_W-1:0]     hint_idx,
  output logic                 hint_vld
);
  logic              armed, wr_go;
  logic [IDX_W-1:0]  wr_idx;
  logic [PRIO_W-1:0] wr_prio;
  logic              wr_dis;

  // active-low lines: invert each field; inverted enable high => disable flag 0
  assign wr_prio = ~addr_n[PRIO_LSB +: PRIO_W];
  assign wr_idx  = ~addr_n[IDX_LSB +: IDX_W];
  assign wr_dis  = addr_n[EN_BIT];

  tpr_phase_tracker u_trk (
    .clk(clk), .rst(rst), .first_stb(first_stb), .addr_stb(addr_stb),
    .armed(armed), .wr_go(wr_go));

  tpr_entry_store #(.N(N), .PRIO_W(PRIO_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_idx(wr_idx),
    .wr_prio(wr_prio), .wr_dis(wr_dis), .rb(readback));

  tpr_lowest_finder #(.N(N), .PRIO_W(PRIO_W), .ENTRY_W(ENTRY_W)) u_find (
    .clk(clk), .rst(rst), .rb(readback), .sel_idx(hint_idx), .sel_vld(hint_vld));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (readback == {N{8'h80}}) && !hint_vld);
  // R6
  stray_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && addr_stb) |=> $stable(readback));
  // R5
  first_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (first_stb && !addr_stb) |=> $stable(readback));
endmodule

// File: tb/tpr_bank_tb_top.sv
module tpr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        first_stb = 1'b0;
  logic        addr_stb = 1'b0;
  logic [31:0] addr_n = '1;
  logic [63:0] readback;
  logic [2:0]  hint_idx;
  logic        hint_vld;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_e [8];

  always #2.5 clk = ~clk;

  tpr_bank dut_i (.clk(clk), .rst(rst), .first_stb(first_stb), .addr_stb(addr_stb),
                  .addr_n(addr_n), .readback(readback), .hint_idx(hint_idx),
                  .hint_vld(hint_vld));

  function automatic logic [31:0] mk(bit en, bit [2:0] idx, bit b23, bit [3:0] p,
                                     bit [31:0] junk);
    logic [31:0] a;
    a = junk & 32'h700F_FFFF;
    a[31] = en; a[27:24] = p; a[23] = b23; a[22:20] = idx;
    return ~a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_upd(input bit en, input bit [2:0] idx, input bit [3:0] p);
    exp_e[idx] = {~en, 3'b000, p};
  endtask

  task automatic check_state(input string req);
    logic [63:0] e;
    logic [2:0] bi; logic bv; logic [3:0] bp;
    bi = 0; bv = 0; bp = '1;
    for (int i = 0; i < 8; i++) begin
      e[i*8 +: 8] = exp_e[i];
      if (!exp_e[i][7] && (!bv || exp_e[i][3:0] < bp)) begin
        bv = 1; bi = 3'(i); bp = exp_e[i][3:0];
      end
    end
    chk(readback == e, {req, " readback"}, readback, e);
    chk(hint_vld == bv && (!bv || hint_idx == bi), {req, " hint"},
        {60'd0, hint_vld, hint_idx}, {60'd0, bv, bi});
  endtask

  task automatic send(input logic [31:0] an);
    @(negedge clk); first_stb = 1; addr_stb = 1; addr_n = '1;
    @(negedge clk); first_stb = 0; addr_stb = 1; addr_n = an;
    @(negedge clk); addr_stb = 0; addr_n = '1;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) exp_e[i] = 8'h80;
    chk(readback == 64'h8080_8080_8080_8080, "R1 reset readback", readback,
        64'h8080_8080_8080_8080);
    chk(!hint_vld, "R1 reset hint_vld", {63'd0, hint_vld}, 64'd0);
  endtask

  task automatic t_basic;
    send(mk(1, 3'd3, 0, 4'd5, 32'h0));
    model_upd(1, 3'd3, 4'd5);
    chk(readback[31:24] == 8'h05, "R2 agent3 byte", {56'd0, readback[31:24]}, 64'h05);
    check_state("R3 basic write");
    send(mk(0, 3'd7, 0, 4'hA, 32'h0));
    model_upd(0, 3'd7, 4'hA);
    chk(readback[63:56] == 8'h8A, "R2 agent7 disabled byte", {56'd0, readback[63:56]},
        64'h8A);
    check_state("R3 disabled write");
  endtask

  task automatic t_ignored_bits;
    send(mk(1, 3'd1, 1, 4'd2, 32'hFFFF_FFFF));
    model_upd(1, 3'd1, 4'd2);
    check_state("R4 bit23 and junk");
  endtask

  task automatic t_first_phase;
    @(negedge clk); first_stb = 1; addr_stb = 1; addr_n = mk(1, 3'd6, 0, 4'd0, 0);
    @(negedge clk); first_stb = 0; addr_stb = 0; addr_n = '1;
    check_state("R5 first phase no write");
    repeat (3) @(negedge clk);
    addr_stb = 1; addr_n = mk(1, 3'd6, 0, 4'd9, 0);
    @(negedge clk); addr_stb = 0; addr_n = '1;
    model_upd(1, 3'd6, 4'd9);
    check_state("R5 armed across idle");
  endtask

  task automatic t_stray;
    @(negedge clk); addr_stb = 1; addr_n = mk(1, 3'd0, 0, 4'd0, 0);
    @(negedge clk); addr_stb = 0; addr_n = '1;
    check_state("R6 stray strobe");
    send(mk(1, 3'd4, 0, 4'd7, 0));
    model_upd(1, 3'd4, 4'd7);
    @(negedge clk); addr_stb = 1; addr_n = mk(1, 3'd4, 0, 4'd0, 0);
    @(negedge clk); addr_stb = 0; addr_n = '1;
    check_state("R6 repeat after write");
  endtask

  task automatic t_hint;
    send(mk(1, 3'd5, 0, 4'd1, 0)); model_upd(1, 3'd5, 4'd1);
    send(mk(1, 3'd2, 0, 4'd1, 0)); model_upd(1, 3'd2, 4'd1);
    chk(hint_vld && hint_idx == 3'd2, "R7 tie lower id", {61'd0, hint_idx}, 64'd2);
    check_state("R8 hint tie");
    send(mk(0, 3'd2, 0, 4'd1, 0)); model_upd(0, 3'd2, 4'd1);
    chk(hint_vld && hint_idx == 3'd5, "R9 disable removes", {61'd0, hint_idx}, 64'd5);
    check_state("R9 after disable");
    for (int i = 0; i < 8; i++) begin
      send(mk(0, 3'(i), 0, 4'd3, 0)); model_upd(0, 3'(i), 4'd3);
    end
    chk(!hint_vld, "R8 all disabled vld", {63'd0, hint_vld}, 64'd0);
    check_state("R8 all disabled");
    send(mk(1, 3'd6, 0, 4'hF, 0)); model_upd(1, 3'd6, 4'hF);
    check_state("R8 single max prio");
  endtask

  initial begin
    #(200000 * 5ns);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_ignored_bits();
    t_first_phase();
    t_stray();
    t_hint();
    t_reset();
    check_state("R1 second reset");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule